// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers fifteen interrupt sources into a sixteen-bit pending register and filters it through a sixteen-bit mask register. While the global enable is set, it picks the highest-priority pending request that is allowed through. It then gives the processor a one-cycle request strobe together with a vector address. Each level has a four-word slot in the vector table. The lowest slot is kept for a special case: a disable command that arrives in the same cycle as a request.

Software works on the block through a small register port:

- A direct write to the pending register ORs new bits in, which raises software interrupts.
- A separate write-one-to-clear command removes pending bits.
- The mask register can be written and read back.
- Two command inputs set and clear the global enable.

A sixteen-bit fault register is ORed into the machine-error level. Some of its bits follow fault pins, and those bits stay set for as long as their pin is asserted.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, the pending, mask and fault registers read 0x0000, the global enable is 0, `irq_req_o` is low and `irq_vec_o` is 0x0000.
- R2: A source held high on `src_i[k]` sets pending bit k at the next clock edge. This holds for k = 15, 13..1. The bit is set again every cycle while the source stays high. `src_i[14]` and `src_i[0]` have no effect, and pending bit 0 never becomes 1.
- R3: When requests compete, the highest-numbered eligible pending bit k is served. Its vector is 0x400 + 4*(15-k), so bit 15 gets 0x400 and bit 1 gets 0x438.
- R4: A pending bit is eligible when its mask bit is 1. Pending bits 15 and 10 are eligible whatever their mask bit holds.
- R5: A write with `wr_sel_i` = 1 (clear) clears every pending bit whose data bit is 1 and leaves all other pending bits unchanged.
- R6: A write with `wr_sel_i` = 0 (pending) ORs the data into the pending register. Data bit 0 is ignored.
- R7: A write with `wr_sel_i` = 2 loads the mask. Read selects are 0 = pending, 2 = mask, 3 = fault, and select 1 reads 0x0000.
- R8: A write with `wr_sel_i` = 3 loads the fault register. Fault bits 13 and 8 follow `fault_pin_i` and stay 1 while their pin is high. The other pin bits are ignored. Any nonzero fault value sets pending bit 14 one cycle later.
- R9: When the enable is 1 and an eligible bit exists, the edge that follows raises `irq_req_o` for exactly one cycle with the vector. The same edge clears the enable and the served pending bit.
- R10: `ie_set_i` sets the enable and `ie_clr_i` clears it. When both are high in the same cycle, clear wins. No request is issued while the enable is 0.
- R11: If `ie_clr_i` is high in a cycle where the enable is 1 and an eligible bit exists, the block issues the strobe with vector 0x43C. It clears the enable and leaves the pending register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| src_i | input | 16 | Level interrupt sources, one per pending bit |
| fault_pin_i | input | 16 | Fault pin levels; only the bits the pin mask selects are used |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write target: 0 set pending, 1 clear pending, 2 mask, 3 fault |
| wr_data_i | input | 16 | Write data |
| rd_sel_i | input | 2 | Read select: 0 pending, 2 mask, 3 fault, 1 reads zero |
| rd_data_o | output | 16 | Combinational read data |
| ie_set_i | input | 1 | Enable command |
| ie_clr_i | input | 1 | Disable command |
| irq_req_o | output | 1 | One-cycle interrupt request strobe |
| irq_vec_o | output | 16 | Vector address of the last request |

## Verification
The bench builds the block with its default parameters:

- sixteen levels;
- vector base 0x400 with a four-word step;
- unmaskable levels 15 and 10;
- pin-held fault bits 13 and 8.

With these values every level's vector through 0x438 can be reached, as can both unmaskable levels, the spare 0x43C slot, and the case where a pin holds a fault bit against a software write. Random mask and pending patterns exercise the priority choice across all levels. Directed sequences cover the same-cycle enable and disable, the coincident disable, sources held against a clear, and pin bits outside the mask.

// File: rtl/irq_vector_pkg.sv
package irq_vector_pkg;

  // Register port selects; the write and read sides share the encoding.
  typedef enum logic [1:0] {
    SEL_PEND     = 2'd0,
    SEL_PEND_CLR = 2'd1,
    SEL_MASK     = 2'd2,
    SEL_FAULT    = 2'd3
  } irq_sel_e;

endpackage

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int W  = 16,
  localparam int IW = $clog2(W)
) (
  input  logic [W-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx,
  output logic [W-1:0]  grant
);

  // above[i] is 1 when some request above bit i is present.
  logic [W-1:0] above;

  assign above[W-1] = 1'b0;

  genvar gi;
  generate
    for (gi = W - 2; gi >= 0; gi--) begin : g_chain
      assign above[gi] = above[gi+1] | req[gi+1];
    end
  endgenerate

  assign grant = req & ~above;
  assign any   = |req;

  // grant is one-hot or zero, so ORing the indices encodes it.
  always_comb begin
    idx = '0;
    for (int i = 0; i < W; i++) begin
      if (grant[i]) idx = idx | IW'(i);
    end
  end

endmodule

// File: rtl/irq_pend_reg.sv
module irq_pend_reg #(
  parameter int               W          = 16,
  parameter logic [W-1:0]     VALID_MASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] hw_set,
  input  logic         sw_set_en,
  input  logic         sw_clr_en,
  input  logic [W-1:0] sw_data,
  input  logic [W-1:0] served,
  output logic [W-1:0] pend_q
);

  logic [W-1:0] pend_d;
  logic [W-1:0] clr_bits;
  logic [W-1:0] set_bits;
  logic         pend_en;

  always_comb begin
    clr_bits = sw_clr_en ? sw_data : '0;
    set_bits = hw_set | (sw_set_en ? sw_data : '0);
    // Sources and writes win over clears and over the served bit.
    pend_d   = ((pend_q & ~clr_bits & ~served) | set_bits) & VALID_MASK;
    pend_en  = (|hw_set) | sw_set_en | sw_clr_en | (|served);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else if (pend_en) begin
      pend_q <= pend_d;
    end
  end

endmodule

// File: rtl/irq_fault_reg.sv
module irq_fault_reg #(
  parameter int           W        = 16,
  parameter logic [W-1:0] PIN_MASK = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic [W-1:0] pins,
  output logic [W-1:0] fault_q,
  output logic         any_fault
);

  logic [W-1:0] pin_bits;
  logic [W-1:0] fault_d;
  logic         fault_en;

  always_comb begin
    pin_bits = pins & PIN_MASK;
    // A pin that is still high forces its bit over any written value.
    fault_d  = (wr_en ? wr_data : fault_q) | pin_bits;
    fault_en = wr_en | (|pin_bits);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_q <= '0;
    end else if (fault_en) begin
      fault_q <= fault_d;
    end
  end

  assign any_fault = |fault_q;

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irq_vector_pkg::*;
#(
  parameter int                 LVL_W     = 16,
  parameter int                 VEC_W     = 16,
  parameter int                 VEC_BASE  = 'h400,
  parameter int                 VEC_STEP  = 4,
  parameter int                 MERR_BIT  = 14,
  parameter logic [LVL_W-1:0]   NOMASK    = 'h8400,
  parameter logic [LVL_W-1:0]   FLT_PINS  = 'h2100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] src_i,
  input  logic [LVL_W-1:0] fault_pin_i,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_sel_i,
  input  logic [LVL_W-1:0] wr_data_i,
  input  logic [1:0]       rd_sel_i,
  output logic [LVL_W-1:0] rd_data_o,
  input  logic             ie_set_i,
  input  logic             ie_clr_i,
  output logic             irq_req_o,
  output logic [VEC_W-1:0] irq_vec_o
);

  localparam int               IDX_W      = $clog2(LVL_W);
  localparam logic [LVL_W-1:0] BIT0       = LVL_W'(1);
  localparam logic [LVL_W-1:0] MERR_ONE   = LVL_W'(1) << MERR_BIT;
  localparam logic [LVL_W-1:0] VALID_MASK = ~BIT0;
  localparam logic [LVL_W-1:0] SRC_MASK   = ~(BIT0 | MERR_ONE);
  localparam logic [VEC_W-1:0] SPARE_VEC  = VEC_W'(VEC_BASE + VEC_STEP * (LVL_W - 1));

  // Reset synchronizer: asserts asynchronously, releases on the clock.
  logic [1:0] rst_sync_q;
  logic       core_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign core_rst_n = rst_sync_q[1];

  // Decode of the register port.
  irq_sel_e wsel;
  irq_sel_e rsel;
  logic     wr_pend;
  logic     wr_clr;
  logic     wr_mask;
  logic     wr_fault;

  assign wsel     = irq_sel_e'(wr_sel_i);
  assign rsel     = irq_sel_e'(rd_sel_i);
  assign wr_pend  = wr_en_i && (wsel == SEL_PEND);
  assign wr_clr   = wr_en_i && (wsel == SEL_PEND_CLR);
  assign wr_mask  = wr_en_i && (wsel == SEL_MASK);
  assign wr_fault = wr_en_i && (wsel == SEL_FAULT);

  // Fault register and machine-error level.
  logic [LVL_W-1:0] fault_q;
  logic             merr;

  irq_fault_reg #(
    .W        (LVL_W),
    .PIN_MASK (FLT_PINS)
  ) u_fault (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .wr_en     (wr_fault),
    .wr_data   (wr_data_i),
    .pins      (fault_pin_i),
    .fault_q   (fault_q),
    .any_fault (merr)
  );

  // Pending register.
  logic [LVL_W-1:0] hw_set;
  logic [LVL_W-1:0] served;
  logic [LVL_W-1:0] pend_q;

  assign hw_set = (src_i & SRC_MASK) | (merr ? MERR_ONE : '0);

  irq_pend_reg #(
    .W          (LVL_W),
    .VALID_MASK (VALID_MASK)
  ) u_pend (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .hw_set    (hw_set),
    .sw_set_en (wr_pend),
    .sw_clr_en (wr_clr),
    .sw_data   (wr_data_i),
    .served    (served),
    .pend_q    (pend_q)
  );

  // Mask register.
  logic [LVL_W-1:0] mask_q;
  logic [LVL_W-1:0] mask_d;

  always_comb mask_d = wr_data_i;

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      mask_q <= '0;
    end else if (wr_mask) begin
      mask_q <= mask_d;
    end
  end

  // Priority choice among eligible pending bits.
  logic [LVL_W-1:0] eligible;
  logic             win_any;
  logic [IDX_W-1:0] win_idx;
  logic [LVL_W-1:0] win_grant;

  assign eligible = pend_q & (mask_q | NOMASK);

  irq_prio_enc #(
    .W (LVL_W)
  ) u_prio (
    .req   (eligible),
    .any   (win_any),
    .idx   (win_idx),
    .grant (win_grant)
  );

  // Service decision, enable, and registered strobe and vector.
  logic             ie_q;
  logic             ie_d;
  logic             service;
  logic             take;
  logic             coincident;
  logic [VEC_W-1:0] vec_pick;
  logic [VEC_W-1:0] vec_d;
  logic             req_q;
  logic [VEC_W-1:0] vec_q;

  always_comb begin
    service    = ie_q & win_any;
    take       = service & ~ie_clr_i;
    coincident = service & ie_clr_i;
    served     = take ? win_grant : '0;
    vec_pick   = VEC_W'(VEC_BASE + VEC_STEP * ((LVL_W - 1) - int'(win_idx)));
    vec_d      = coincident ? SPARE_VEC : vec_pick;
    if (service) begin
      ie_d = 1'b0;
    end else if (ie_clr_i) begin
      ie_d = 1'b0;
    end else if (ie_set_i) begin
      ie_d = 1'b1;
    end else begin
      ie_d = ie_q;
    end
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      ie_q  <= 1'b0;
      req_q <= 1'b0;
    end else begin
      ie_q  <= ie_d;
      req_q <= service;
    end
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      vec_q <= '0;
    end else if (service) begin
      vec_q <= vec_d;
    end
  end

  assign irq_req_o = req_q;
  assign irq_vec_o = vec_q;

  // Read-back.
  always_comb begin
    unique case (rsel)
      SEL_PEND:  rd_data_o = pend_q;
      SEL_MASK:  rd_data_o = mask_q;
      SEL_FAULT: rd_data_o = fault_q;
      default:   rd_data_o = '0;
    endcase
  end

endmodule

// File: rtl/irq_vector_chk.sv
module irq_vector_chk #(
  parameter int               LVL_W    = 16,
  parameter int               VEC_W    = 16,
  parameter int               VEC_BASE = 'h400,
  parameter int               VEC_STEP = 4,
  parameter int               MERR_BIT = 14,
  parameter logic [LVL_W-1:0] FLT_PINS = 'h2100
) (
  input logic             clk,
  input logic             rst_n,
  input logic [LVL_W-1:0] pend_q,
  input logic [LVL_W-1:0] fault_q,
  input logic [LVL_W-1:0] fault_pin_i,
  input logic             ie_q,
  input logic             irq_req,
  input logic [VEC_W-1:0] irq_vec
);

  localparam logic [VEC_W-1:0] LO_VEC = VEC_W'(VEC_BASE);
  localparam logic [VEC_W-1:0] HI_VEC = VEC_W'(VEC_BASE + VEC_STEP * (LVL_W - 1));

  p_bit0_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q[0] == 1'b0);

  p_vec_in_table_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_vec[1:0] == 2'b00 && irq_vec >= LO_VEC && irq_vec <= HI_VEC));

  p_fault_pends_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|fault_q) |=> pend_q[MERR_BIT]);

  p_pin_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|(fault_pin_i & FLT_PINS)) |=>
      ((fault_q & $past(fault_pin_i & FLT_PINS)) == $past(fault_pin_i & FLT_PINS)));

  p_take_drops_ie_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> !ie_q);

  p_strobe_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |=> !irq_req);

  p_quiet_when_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !ie_q |=> !irq_req);

endmodule

bind irq_vector_ctrl irq_vector_chk #(
  .LVL_W    (LVL_W),
  .VEC_W    (VEC_W),
  .VEC_BASE (VEC_BASE),
  .VEC_STEP (VEC_STEP),
  .MERR_BIT (MERR_BIT),
  .FLT_PINS (FLT_PINS)
) u_chk (
  .clk         (clk),
  .rst_n       (core_rst_n),
  .pend_q      (pend_q),
  .fault_q     (fault_q),
  .fault_pin_i (fault_pin_i),
  .ie_q        (ie_q),
  .irq_req     (irq_req_o),
  .irq_vec     (irq_vec_o)
);

// File: tb/irq_vector_ctrl_tb.sv
`timescale 1ns/1ps
module irq_vector_ctrl_tb;

  logic        clk;
  logic        rst_n;
  logic [15:0] src_i;
  logic [15:0] fault_pin_i;
  logic        wr_en_i;
  logic [1:0]  wr_sel_i;
  logic [15:0] wr_data_i;
  logic [1:0]  rd_sel_i;
  logic [15:0] rd_data_o;
  logic        ie_set_i;
  logic        ie_clr_i;
  logic        irq_req_o;
  logic [15:0] irq_vec_o;

  int n_chk;
  int n_fail;
  bit done;

  irq_vector_ctrl u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .src_i       (src_i),
    .fault_pin_i (fault_pin_i),
    .wr_en_i     (wr_en_i),
    .wr_sel_i    (wr_sel_i),
    .wr_data_i   (wr_data_i),
    .rd_sel_i    (rd_sel_i),
    .rd_data_o   (rd_data_o),
    .ie_set_i    (ie_set_i),
    .ie_clr_i    (ie_clr_i),
    .irq_req_o   (irq_req_o),
    .irq_vec_o   (irq_vec_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  localparam logic [1:0] S_PEND = 2'd0;
  localparam logic [1:0] S_CLR  = 2'd1;
  localparam logic [1:0] S_MASK = 2'd2;
  localparam logic [1:0] S_FLT  = 2'd3;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Highest eligible level, or -1 when none.
  function automatic int model_top(input logic [15:0] p, input logic [15:0] m);
    logic [15:0] el;
    el = p & (m | 16'h8400) & 16'hFFFE;
    for (int k = 15; k >= 1; k--) begin
      if (el[k]) return k;
    end
    return -1;
  endfunction

  function automatic logic [15:0] model_vec(input int k);
    return 16'(16'h400 + 4 * (15 - k));
  endfunction

  // All stimulus tasks start and end just after a falling edge.
  task automatic wr(input logic [1:0] sel, input logic [15:0] d);
    wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = d;
    @(negedge clk);
    wr_en_i = 1'b0; wr_data_i = '0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [15:0] d);
    rd_sel_i = sel;
    #1;
    d = rd_data_o;
  endtask

  task automatic cmd(input logic en, input logic dis);
    ie_set_i = en; ie_clr_i = dis;
    @(negedge clk);
    ie_set_i = 1'b0; ie_clr_i = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [15:0] d;
    logic [15:0] m;
    logic [15:0] p;
    int          k;
    n_chk = 0; n_fail = 0; done = 1'b0;
    src_i = '0; fault_pin_i = '0; wr_en_i = 1'b0; wr_sel_i = '0; wr_data_i = '0;
    rd_sel_i = '0; ie_set_i = 1'b0; ie_clr_i = 1'b0;
    rst_n = 1'b0;
    void'($urandom(32'd2024));
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R1 reset state
    for (int s = 0; s < 4; s++) begin
      rd(2'(s), d);
      chk($sformatf("R1 readback sel %0d", s), d, 16'h0000);
    end
    chk("R1 strobe low", irq_req_o, 1'b0);
    chk("R1 vector zero", irq_vec_o, 16'h0000);

    // R2 each source alone, enable off and mask closed
    for (int b = 0; b < 16; b++) begin
      src_i = 16'(1) << b;
      @(negedge clk);
      src_i = '0;
      rd(S_PEND, d);
      chk($sformatf("R2 source bit %0d", b), d, (b == 0 || b == 14) ? 16'h0 : (16'(1) << b));
      wr(S_CLR, 16'hFFFF);
    end
    // R2 held source defeats a clear
    src_i = 16'h0080;
    idle(1);
    wr(S_CLR, 16'h0080);
    rd(S_PEND, d);
    chk("R2 held source survives clear", d, 16'h0080);
    src_i = '0;
    wr(S_CLR, 16'h0080);
    rd(S_PEND, d);
    chk("R2 released source clears", d, 16'h0000);

    // R6 set by OR, bit 0 ignored
    wr(S_PEND, 16'h0002);
    wr(S_PEND, 16'h1001);
    rd(S_PEND, d);
    chk("R6 direct write ORs", d, 16'h1002);
    // R5 write-one-to-clear
    wr(S_PEND, 16'hF0F0);
    wr(S_CLR, 16'h3032);
    rd(S_PEND, d);
    chk("R5 selective clear", d, 16'hC0C0);
    wr(S_CLR, 16'hFFFF);

    // R7 mask readback and read select 1
    m = 16'($urandom);
    wr(S_MASK, m);
    rd(S_MASK, d);
    chk("R7 mask readback", d, m);
    rd(S_CLR, d);
    chk("R7 select 1 reads zero", d, 16'h0000);
    wr(S_MASK, 16'h0000);

    // R10 both commands together: clear wins
    wr(S_PEND, 16'h8000);
    cmd(1'b1, 1'b1);
    idle(2);
    chk("R10 no strobe after set+clear", irq_req_o, 1'b0);
    rd(S_PEND, d);
    chk("R10 pending kept while off", d, 16'h8000);

    // R4 unmaskable level 15, mask all zero
    cmd(1'b1, 1'b0);
    @(negedge clk);
    chk("R4 level 15 strobe", irq_req_o, 1'b1);
    chk("R4 level 15 vector", irq_vec_o, 16'h0400);
    rd(S_PEND, d);
    chk("R9 served bit cleared", d, 16'h0000);
    idle(1);
    chk("R9 strobe one cycle", irq_req_o, 1'b0);

    // R4 unmaskable level 10
    wr(S_PEND, 16'h0400);
    cmd(1'b1, 1'b0);
    @(negedge clk);
    chk("R4 level 10 vector", {15'b0, irq_req_o, irq_vec_o}, {15'b0, 1'b1, 16'h0414});

    // R4 masked level 5 stays pending
    wr(S_PEND, 16'h0020);
    cmd(1'b1, 1'b0);
    idle(2);
    chk("R4 masked level no strobe", irq_req_o, 1'b0);

    // R11 coincident disable
    cmd(1'b0, 1'b1);
    wr(S_MASK, 16'h0020);
    cmd(1'b1, 1'b0);
    cmd(1'b0, 1'b1);
    chk("R11 coincident strobe", irq_req_o, 1'b1);
    chk("R11 coincident vector", irq_vec_o, 16'h043C);
    rd(S_PEND, d);
    chk("R11 pending untouched", d, 16'h0020);
    idle(2);
    chk("R11 enable dropped", irq_req_o, 1'b0);
    cmd(1'b1, 1'b0);
    @(negedge clk);
    chk("R3 level 5 after re-enable", irq_vec_o, 16'h0428);
    idle(1);

    // R8 pin-held fault bit
    wr(S_MASK, 16'h0000);
    fault_pin_i = 16'h2000;
    idle(1);
    wr(S_FLT, 16'h0000);
    rd(S_FLT, d);
    chk("R8 pin bit held against write", d, 16'h2000);
    idle(1);
    rd(S_PEND, d);
    chk("R8 fault raises level 14", d[14], 1'b1);
    fault_pin_i = 16'h0001;
    wr(S_FLT, 16'h0000);
    idle(1);
    rd(S_FLT, d);
    chk("R8 unselected pin ignored", d, 16'h0000);
    wr(S_CLR, 16'hFFFF);
    rd(S_PEND, d);
    chk("R8 level 14 clears once fault gone", d, 16'h0000);
    fault_pin_i = '0;
    wr(S_FLT, 16'h0005);
    rd(S_FLT, d);
    chk("R8 software fault bits", d, 16'h0005);
    idle(1);
    rd(S_PEND, d);
    chk("R8 software fault raises level 14", d, 16'h4000);
    wr(S_FLT, 16'h0000);
    wr(S_CLR, 16'hFFFF);

    // R3 random patterns
    for (int t = 0; t < 60; t++) begin
      cmd(1'b0, 1'b1);
      wr(S_CLR, 16'hFFFF);
      m = 16'($urandom);
      p = 16'($urandom) & ((t % 4 == 0) ? 16'h00F0 : 16'hFFFF);
      wr(S_MASK, m);
      wr(S_PEND, p);
      rd(S_PEND, d);
      chk("R6 random pending write", d, p & 16'hFFFE);
      cmd(1'b1, 1'b0);
      @(negedge clk);
      k = model_top(p, m);
      if (k < 0) begin
        chk("R4 random none eligible", irq_req_o, 1'b0);
      end else begin
        chk("R3 random strobe", irq_req_o, 1'b1);
        chk("R3 random vector", irq_vec_o, model_vec(k));
        rd(S_PEND, d);
        chk("R9 random served bit cleared", d, (p & 16'hFFFE) & ~(16'(1) << k));
      end
      idle(1);
    end

    finish_run();
  end

endmodule